// File: doc/BRIEF.md
# Read-After-Write Hazard Interlock

This block detects data hazards in a small in-order five-stage pipeline and stalls the pipeline until they clear. The stages, in order, are fetch, register read, ALU, data memory and register writeback. The register bank is written only in writeback and read only in register read. A value written in a cycle cannot be read back in that same cycle. An instruction that directly follows its producer would therefore read two cycles before the write lands, unless it is held.

Each cycle the block receives the decoded fields of the instruction sitting in register read. These are its valid bit, its write enable and destination index, and two source indices, each with a use flag. The block keeps its own copy of the valid, write-enable and destination tags for the ALU, memory and writeback stages. When a used source matches an older instruction that is valid and will write that register, the block raises `hold`, which freezes the fetch and register-read stage registers. It also raises `bubble`, so that a no-op that writes nothing enters the ALU stage instead of the held instruction.

Without forwarding, a dependent instruction waits until its producer has left writeback, which costs up to three bubbles. With `fwd_en` high, a bypass from the writeback result into register read is allowed. The wait then ends once the producer reaches writeback, which costs up to two bubbles, and the per-operand select `fwd_a` or `fwd_b` picks the bypass for that operand.

Top module: `hazard_interlock`

## Requirements
- R1: A synchronous reset clears every in-flight tag. After reset, no instruction is held, whatever registers it reads, and this also holds when producers were in flight when reset was asserted.
- R2: With `fwd_en` low, an instruction that reads a register written by the instruction directly ahead of it is held for exactly 3 cycles.
- R3: With `fwd_en` high, the same directly dependent instruction is held for exactly 2 cycles. In the cycle it is accepted, the forward select of the matching operand (`fwd_a` for source A, `fwd_b` for source B) is 1 and the other select is 0.
- R4: When the producer is 2, 3 or 4 instructions or bubbles ahead, the hold shortens to the remaining cycles. Without forwarding this is 2, 1 and 0 cycles. With forwarding it is 1, 0 and 0 cycles, and the forward select is 1 at distances 2 and 3.
- R5: Only older instructions that are valid and have their write enable set can cause a hold. A non-writing instruction, or an empty slot (`id_valid` low), never does.
- R6: Each source is checked on its own and only when its use flag is 1. Sources A and B may each depend on a different producer, and each gets its own forward select.
- R7: When several in-flight instructions write the same register, the youngest of them sets the hold length and the forwarding source.
- R8: `hold` and `bubble` are asserted together, only while the instruction in register read is valid. Each held cycle sends an empty, non-writing slot into the ALU stage.
- R9: `fwd_a` and `fwd_b` are 1 only while `fwd_en` is 1, the instruction is valid and `hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_en | input | 1 | Allow the writeback-to-register-read bypass |
| id_valid | input | 1 | Register-read stage holds a real instruction |
| id_wen | input | 1 | That instruction writes a register |
| id_dst | input | 4 | Destination register index |
| id_use_a | input | 1 | Source A is read |
| id_src_a | input | 4 | Source A register index |
| id_use_b | input | 1 | Source B is read |
| id_src_b | input | 4 | Source B register index |
| hold | output | 1 | Freeze fetch and register-read stage registers |
| bubble | output | 1 | Put a no-op into the ALU stage |
| fwd_a | output | 1 | Source A takes the writeback result |
| fwd_b | output | 1 | Source B takes the writeback result |

## Verification
The hardest case to reach is one where the two operands depend on different producers at different distances while forwarding is on. Only then do the youngest-producer choice, the independent per-operand selects and the shortened stall all matter in the same cycle. The stimulus issues two back-to-back producers and then a consumer that reads one result on each operand. It also issues two writers of the same register ahead of a reader. A reset taken while producers are still in flight shows that the cleared tags cannot raise a stall afterwards.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fwd_en,
  input  logic                        id_valid,
  input  logic                        id_wen,
  input  logic [$clog2(NUM_REGS)-1:0] id_dst,
  input  logic                        id_use_a,
  input  logic [$clog2(NUM_REGS)-1:0] id_src_a,
  input  logic                        id_use_b,
  input  logic [$clog2(NUM_REGS)-1:0] id_src_b,
  output logic                        hold,
  output logic                        bubble,
  output logic                        fwd_a,
  output logic                        fwd_b
);
  localparam int RW    = $clog2(NUM_REGS);
  localparam int DEPTH = 3;
  localparam int LAST  = DEPTH - 1;

  // index 0 = ALU stage, 1 = memory stage, 2 = writeback stage
  logic [DEPTH-1:0] vld, wen, hit_a, hit_b;
  logic [RW-1:0]    dst [DEPTH];
  logic             blk_a, blk_b;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      hit_a[k] = vld[k] && wen[k] && id_use_a && (dst[k] == id_src_a);
      hit_b[k] = vld[k] && wen[k] && id_use_b && (dst[k] == id_src_b);
    end
  end

  assign blk_a  = (|hit_a[LAST-1:0]) || (hit_a[LAST] && !fwd_en);
  assign blk_b  = (|hit_b[LAST-1:0]) || (hit_b[LAST] && !fwd_en);
  assign hold   = id_valid && (blk_a || blk_b);
  assign bubble = hold;
  assign fwd_a  = id_valid && fwd_en && !hold && hit_a[LAST];
  assign fwd_b  = id_valid && fwd_en && !hold && hit_b[LAST];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAST-1:0], id_valid && !hold};
  end

  always_ff @(posedge clk) begin
    wen    <= {wen[LAST-1:0], id_wen};
    dst[0] <= id_dst;
    for (int k = 1; k < DEPTH; k++) dst[k] <= dst[k-1];
  end

  logic [2:0] hold_run;
  always_ff @(posedge clk) begin
    if (rst)       hold_run <= '0;
    else if (hold) hold_run <= hold_run + 3'd1;
    else           hold_run <= '0;
  end

  p_clear_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (vld == '0));
  p_stall_limit_r4: assert property (@(posedge clk) disable iff (rst)
    hold |-> (hold_run < 3'(DEPTH)));
  p_bubble_enters_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> !vld[0]);
  p_hold_needs_instr_r8: assert property (@(posedge clk) disable iff (rst)
    hold |-> id_valid);
  p_fwd_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (fwd_a || fwd_b) |-> (fwd_en && !hold));
  p_tags_advance_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld[LAST:1] == $past(vld[LAST-1:0])));
endmodule

// File: tb/test_hazard_interlock.sv
module test_hazard_interlock;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, fwd_en = 0;
  logic id_valid = 0, id_wen = 0, id_use_a = 0, id_use_b = 0;
  logic [3:0] id_dst = 0, id_src_a = 0, id_src_b = 0;
  logic hold, bubble, fwd_a, fwd_b;

  hazard_interlock i_hazard_interlock (
    .clk(clk), .rst(rst), .fwd_en(fwd_en),
    .id_valid(id_valid), .id_wen(id_wen), .id_dst(id_dst),
    .id_use_a(id_use_a), .id_src_a(id_src_a),
    .id_use_b(id_use_b), .id_src_b(id_src_b),
    .hold(hold), .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int stalls; bit fa; bit fb; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: %0d expected items left, expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // driver: present one instruction, push its expectation, wait until accepted
  task automatic issue(input bit we, input logic [3:0] dst,
                       input bit ua, input logic [3:0] sa,
                       input bit ub, input logic [3:0] sb,
                       input int est, input bit efa, input bit efb, input string req);
    exp_t e;
    @(negedge clk);
    id_valid = 1; id_wen = we; id_dst = dst;
    id_use_a = ua; id_src_a = sa; id_use_b = ub; id_src_b = sb;
    e.stalls = est; e.fa = efa; e.fb = efb; e.req = req;
    exp_q.push_back(e);
    #1;
    while (hold) begin @(negedge clk); #1; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      id_valid = 0; id_wen = 0; id_use_a = 0; id_use_b = 0;
    end
  endtask

  // filler: writes r15, reads nothing
  task automatic filler();
    issue(1, 4'd15, 0, 0, 0, 0, 0, 0, 0, "R4");
  endtask

  // monitor: count held cycles, compare at the accept cycle
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk); #2;
      if (!rst && id_valid) begin
        checks++;
        if (bubble !== hold) begin
          fails++;
          $display("FAIL R8: bubble=%0b expected hold=%0b", bubble, hold);
        end
        if (hold) begin
          cnt++;
          checks++;
          if (fwd_a || fwd_b) begin
            fails++;
            $display("FAIL R9: fwd during hold a=%0b b=%0b expected 0 0", fwd_a, fwd_b);
          end
        end else begin
          exp_t e;
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: accept with empty queue, stalls=%0d expected none", cnt);
          end else begin
            e = exp_q.pop_front();
            if (cnt != e.stalls || fwd_a != e.fa || fwd_b != e.fb) begin
              fails++;
              $display("FAIL %s: stalls=%0d fa=%0b fb=%0b expected stalls=%0d fa=%0b fb=%0b",
                       e.req, cnt, fwd_a, fwd_b, e.stalls, e.fa, e.fb);
            end
          end
          cnt = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (hold !== 0 || fwd_a !== 0 || fwd_b !== 0) begin
      fails++;
      $display("FAIL R1: in reset hold=%0b fa=%0b fb=%0b expected 0 0 0", hold, fwd_a, fwd_b);
    end
    @(negedge clk); rst = 0;

    // R1: fresh out of reset, nothing in flight
    issue(1, 4'd2, 1, 4'd1, 1, 4'd0, 0, 0, 0, "R1");
    idle(4);

    // R2: adjacent dependence, no forwarding
    fwd_en = 0;
    issue(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R2");
    issue(1, 4'd4, 1, 4'd3, 0, 0, 3, 0, 0, "R2");
    idle(4);

    // R3: adjacent dependence, forwarding, on A then on B
    fwd_en = 1;
    issue(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R3");
    issue(1, 4'd4, 1, 4'd3, 0, 0, 2, 1, 0, "R3");
    idle(4);
    issue(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R3");
    issue(1, 4'd4, 0, 0, 1, 4'd3, 2, 0, 1, "R3");
    idle(4);

    // R4: distances 2, 3, 4 without and with forwarding
    for (int fw = 0; fw < 2; fw++) begin
      fwd_en = fw[0];
      for (int g = 1; g <= 3; g++) begin
        int est;
        bit ef;
        est = fw ? ((2 - g) > 0 ? 2 - g : 0) : 3 - g;
        ef  = fw && g <= 2;
        issue(1, 4'd5, 0, 0, 0, 0, 0, 0, 0, "R4");
        for (int f = 0; f < g; f++) filler();
        issue(0, 4'd0, 1, 4'd5, 0, 0, est, ef, 0, "R4");
        idle(4);
      end
    end

    // R5: non-writing producer, and an empty slot counting as distance
    fwd_en = 0;
    issue(0, 4'd6, 0, 0, 0, 0, 0, 0, 0, "R5");
    issue(0, 4'd0, 1, 4'd6, 1, 4'd6, 0, 0, 0, "R5");
    idle(4);
    issue(1, 4'd6, 0, 0, 0, 0, 0, 0, 0, "R5");
    idle(1);
    issue(0, 4'd0, 1, 4'd6, 0, 0, 2, 0, 0, "R5");
    idle(4);

    // R6: use flag gates the compare; two operands, two producers
    issue(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, "R6");
    issue(0, 4'd0, 0, 4'd7, 0, 4'd7, 0, 0, 0, "R6");
    idle(4);
    fwd_en = 1;
    issue(1, 4'd1, 0, 0, 0, 0, 0, 0, 0, "R6");
    issue(1, 4'd2, 0, 0, 0, 0, 0, 0, 0, "R6");
    issue(0, 4'd0, 1, 4'd1, 1, 4'd2, 2, 0, 1, "R6");
    idle(4);

    // R7: two writers of one register, youngest decides
    issue(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, "R7");
    issue(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, "R7");
    issue(0, 4'd0, 1, 4'd8, 0, 0, 2, 1, 0, "R7");
    idle(4);
    fwd_en = 0;
    issue(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, "R7");
    filler();
    issue(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, "R7");
    issue(0, 4'd0, 0, 0, 1, 4'd8, 3, 0, 0, "R7");
    idle(4);

    // R8: consumer of a held instruction sees it as its adjacent producer
    issue(1, 4'd9, 0, 0, 0, 0, 0, 0, 0, "R8");
    issue(1, 4'd10, 1, 4'd9, 0, 0, 3, 0, 0, "R8");
    issue(0, 4'd0, 1, 4'd10, 0, 0, 3, 0, 0, "R8");
    idle(4);

    // R1: reset with producers in flight
    issue(1, 4'd11, 0, 0, 0, 0, 0, 0, 0, "R1");
    issue(1, 4'd12, 0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    id_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    issue(0, 4'd0, 1, 4'd11, 1, 4'd12, 0, 0, 0, "R1");
    idle(4);

    finish_run();
  end
endmodule